// File: doc/BRIEF.md
# DDR2 Command Decoder and Bank Tracker

This block sits on the memory side of a DDR2 command bus. At every rising clock edge it samples the chip select, the three command strobes, the clock enable, the bank select and the address bus. From these it decodes one command and keeps a record of which of the eight banks hold an open row and which row that is. Each result appears on registered outputs one cycle after the edge at which the command was sampled.

It checks each command against the bank state and against the clock enable, and it raises a one-cycle error pulse when a command is illegal. An illegal command never changes the bank record. Read and write commands may ask for auto-precharge, and that request closes the bank. The block also follows the clock enable into and out of power-down. It reports the power-down state as a single flag. It drives no data path and it models no analog behaviour.

Top module: `ddr2_cmd_tracker`

## Requirements
- R1: With `cke` high and `cs_n` low, the strobes {ras_n,cas_n,we_n} are decoded as follows, with the code appearing on `cmd` one cycle later:
  - 011 is activate, code 1.
  - 101 is read, code 2.
  - 100 is write, code 3.
  - 010 is precharge. The code is 4 when addr[10] is 0 and 5 (precharge all) when addr[10] is 1.
  - 001 is refresh, code 6.
  - 000 is mode register set, code 7.
  - 111 and 110 are no-op, code 0.
- R2: When `cs_n` is high (deselect) or `cke` is low, `cmd` shows 0 in the next cycle, and the bank record is not changed.
- R3: An activate to an idle bank `ba` sets `bank_open[ba]` and stores `addr` as that bank's row in `open_rows[ba*ROW_W +: ROW_W]`.
- R4: An activate to a bank that is already open pulses `cmd_err` for one cycle. It leaves `bank_open` and `open_rows` unchanged.
- R5: A read or a write to an idle bank pulses `cmd_err` and changes no state.
- R6: A legal read or write with addr[10]=1 clears `bank_open[ba]`. With addr[10]=0 the bank stays open.
- R7: A precharge with addr[10]=0 clears only `bank_open[ba]`; closing an idle bank this way is legal. A precharge with addr[10]=1 clears every bank.
- R8: Refresh is legal only when all eight banks are idle. Otherwise it pulses `cmd_err`.
- R9: `pdown` becomes 1 when `cke` is sampled low one edge after being sampled high, provided that edge carries a no-op or deselect and no error. `pdown` returns to 0 at the first edge where `cke` is sampled high.
- R10: For BURST_CYC (default 4) edges after an accepted read or write, and for MRD_CYC (default 2) edges after an accepted mode register set, dropping `cke` pulses `cmd_err` and does not set `pdown`. Dropping `cke` together with a command other than no-op or deselect does the same.
- R11: After reset, the outputs are as follows: `bank_open` and `open_rows` are 0, `cmd` is 0, `cmd_err` is 0 and `pdown` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; inputs are sampled on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| cke | input | 1 | Clock enable |
| ba | input | 3 | Bank select |
| addr | input | ROW_W (14) | Address bus; bit 10 is the precharge/auto-precharge select |
| cmd | output | 3 | Decoded command code (see R1) |
| cmd_err | output | 1 | One-cycle illegal-command pulse |
| bank_open | output | 8 | Per-bank open flag |
| open_rows | output | 8*ROW_W | Stored row per bank, bank 0 in the low bits |
| pdown | output | 1 | Power-down flag |

## Verification
Two checks can fall in the same edge: the illegal-clock-enable check and the end of a read's busy window. The bench drops `cke` at every offset from zero to six edges after an accepted read. The reference model then decides, edge by edge, whether each drop is flagged as an error or turns into a clean power-down entry. The bench also drops `cke` two edges after a mode register set, and again with a live command on the bus. In all of these cases both the error pulse and the power-down flag are compared against the model in every cycle.

// File: rtl/ddr2_cmd_tracker.sv
module ddr2_cmd_tracker #(
  parameter int ROW_W     = 14,
  parameter int BURST_CYC = 4,
  parameter int MRD_CYC   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_n,
  input  logic               ras_n,
  input  logic               cas_n,
  input  logic               we_n,
  input  logic               cke,
  input  logic [2:0]         ba,
  input  logic [ROW_W-1:0]   addr,
  output logic [2:0]         cmd,
  output logic               cmd_err,
  output logic [7:0]         bank_open,
  output logic [8*ROW_W-1:0] open_rows,
  output logic               pdown
);
  localparam int NB  = 8;
  localparam int CW  = $clog2((BURST_CYC > MRD_CYC ? BURST_CYC : MRD_CYC) + 1);
  localparam logic [2:0] C_NOP = 3'd0, C_ACT = 3'd1, C_RD = 3'd2, C_WR = 3'd3,
                         C_PRE = 3'd4, C_PREA = 3'd5, C_REF = 3'd6, C_MRS = 3'd7;

  logic [2:0]    dec;
  logic          cke_q;
  logic [CW-1:0] busy;
  logic          bad;
  logic          tgt_open;

  always_comb begin
    dec = C_NOP;
    if (!cs_n)
      case ({ras_n, cas_n, we_n})
        3'b011:  dec = C_ACT;
        3'b101:  dec = C_RD;
        3'b100:  dec = C_WR;
        3'b010:  dec = addr[10] ? C_PREA : C_PRE;
        3'b001:  dec = C_REF;
        3'b000:  dec = C_MRS;
        default: dec = C_NOP;
      endcase
  end

  assign tgt_open = bank_open[ba];

  always_comb begin
    bad = 1'b0;
    if (!cke)
      bad = cke_q && (dec != C_NOP || busy != '0);
    else
      case (dec)
        C_ACT:       bad = tgt_open;
        C_RD, C_WR:  bad = !tgt_open;
        C_REF:       bad = |bank_open;
        default:     bad = 1'b0;
      endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cke_q     <= 1'b0;
      busy      <= '0;
      cmd       <= C_NOP;
      cmd_err   <= 1'b0;
      bank_open <= '0;
      open_rows <= '0;
      pdown     <= 1'b0;
    end else begin
      cke_q   <= cke;
      cmd_err <= bad;
      cmd     <= cke ? dec : C_NOP;
      if (cke) pdown <= 1'b0;
      else if (cke_q && !bad) pdown <= 1'b1;
      if (cke && !bad && (dec == C_RD || dec == C_WR))
        busy <= CW'(BURST_CYC);
      else if (cke && dec == C_MRS)
        busy <= CW'(MRD_CYC);
      else if (busy != '0)
        busy <= busy - 1'b1;
      if (cke && !bad)
        case (dec)
          C_ACT: begin
            bank_open[ba] <= 1'b1;
            open_rows[ba*ROW_W +: ROW_W] <= addr;
          end
          C_RD, C_WR: if (addr[10]) bank_open[ba] <= 1'b0;
          C_PRE:  bank_open[ba] <= 1'b0;
          C_PREA: bank_open <= '0;
          default: ;
        endcase
    end
  end
endmodule

module ddr2_cmd_tracker_chk #(parameter int ROW_W = 14) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_n,
  input logic             ras_n,
  input logic             cas_n,
  input logic             we_n,
  input logic             cke,
  input logic [2:0]       ba,
  input logic [ROW_W-1:0] addr,
  input logic             cmd_err,
  input logic [7:0]       bank_open,
  input logic             pdown
);
  logic act_s, rw_s, ref_s, prea_s;
  assign act_s  = cke && !cs_n && {ras_n, cas_n, we_n} == 3'b011;
  assign rw_s   = cke && !cs_n && ras_n && !cas_n;
  assign ref_s  = cke && !cs_n && {ras_n, cas_n, we_n} == 3'b001;
  assign prea_s = cke && !cs_n && {ras_n, cas_n, we_n} == 3'b010 && addr[10];

  assert_act_opens_R3: assert property (@(posedge clk) disable iff (!rst_n)
    act_s && !bank_open[ba] |=> bank_open[$past(ba)] && !cmd_err);
  assert_act_twice_R4: assert property (@(posedge clk) disable iff (!rst_n)
    act_s && bank_open[ba] |=> cmd_err && bank_open == $past(bank_open));
  assert_rw_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rw_s && !bank_open[ba] |=> cmd_err && bank_open == $past(bank_open));
  assert_prea_closes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    prea_s |=> bank_open == 8'h00);
  assert_ref_open_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ref_s && |bank_open |=> cmd_err);
  assert_pd_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cke |=> !pdown);
endmodule

bind ddr2_cmd_tracker ddr2_cmd_tracker_chk #(.ROW_W(ROW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
  .we_n(we_n), .cke(cke), .ba(ba), .addr(addr), .cmd_err(cmd_err),
  .bank_open(bank_open), .pdown(pdown));

// File: tb/ddr2_cmd_tracker_bench.sv
module ddr2_cmd_tracker_bench;
  localparam int RW = 14;
  logic clk = 0, rst_n = 0, cs_n = 1, ras_n = 1, cas_n = 1, we_n = 1, cke = 0;
  logic [2:0] ba = 0;
  logic [RW-1:0] addr = 0;
  logic [2:0] cmd;
  logic cmd_err, pdown;
  logic [7:0] bank_open;
  logic [8*RW-1:0] open_rows;
  int checks = 0, errors = 0;
  string tag = "R11";
  bit live = 0, done = 0;

  ddr2_cmd_tracker u_ddr2_cmd_tracker (.clk(clk), .rst_n(rst_n), .cs_n(cs_n),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cke(cke), .ba(ba), .addr(addr),
    .cmd(cmd), .cmd_err(cmd_err), .bank_open(bank_open), .open_rows(open_rows),
    .pdown(pdown));

  always #2 clk = ~clk;

  int m_cmd, m_busy;
  bit m_err, m_pd, m_ckeq;
  bit m_open[8];
  int m_row[8];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cmd = 0; m_busy = 0; m_err = 0; m_pd = 0; m_ckeq = 0;
      for (int i = 0; i < 8; i++) begin m_open[i] = 0; m_row[i] = 0; end
    end else begin
      int c; bit e; bit anyo;
      c = 0; e = 0; anyo = 0;
      for (int i = 0; i < 8; i++) if (m_open[i]) anyo = 1;
      if (!cs_n) begin
        if (!ras_n && cas_n && we_n) c = 1;
        else if (ras_n && !cas_n && we_n) c = 2;
        else if (ras_n && !cas_n && !we_n) c = 3;
        else if (!ras_n && cas_n && !we_n) c = addr[10] ? 5 : 4;
        else if (!ras_n && !cas_n && we_n) c = 6;
        else if (!ras_n && !cas_n && !we_n) c = 7;
      end
      if (!cke) begin
        if (m_ckeq && (c != 0 || m_busy > 0)) e = 1;
        if (m_ckeq && !e) m_pd = 1;
        m_cmd = 0;
        if (m_busy > 0) m_busy--;
      end else begin
        m_pd = 0; m_cmd = c;
        if (c == 1 && m_open[ba]) e = 1;
        if ((c == 2 || c == 3) && !m_open[ba]) e = 1;
        if (c == 6 && anyo) e = 1;
        if (!e && c == 1) begin m_open[ba] = 1; m_row[ba] = addr; end
        if (!e && (c == 2 || c == 3) && addr[10]) m_open[ba] = 0;
        if (c == 4) m_open[ba] = 0;
        if (c == 5) for (int i = 0; i < 8; i++) m_open[i] = 0;
        if (!e && (c == 2 || c == 3)) m_busy = 4;
        else if (c == 7) m_busy = 2;
        else if (m_busy > 0) m_busy--;
      end
      m_ckeq = cke; m_err = e;
    end
  end

  task automatic chk(string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (live && !done) begin
    chk("cmd", cmd, m_cmd);
    chk("cmd_err", cmd_err, m_err);
    chk("pdown", pdown, m_pd);
    for (int i = 0; i < 8; i++) begin
      chk("bank_open", bank_open[i], m_open[i]);
      chk("open_row", open_rows[i*RW +: RW], m_row[i]);
    end
  end

  task automatic drv(bit c, bit r, bit ca, bit w, bit k, int b, int a);
    cs_n = c; ras_n = r; cas_n = ca; we_n = w; cke = k; ba = 3'(b); addr = RW'(a);
    @(negedge clk);
  endtask
  task automatic nop(int n); for (int i = 0; i < n; i++) drv(0, 1, 1, 1, 1, 0, 0); endtask
  task automatic act(int b, int r); drv(0, 0, 1, 1, 1, b, r); endtask
  task automatic rd(int b, int a); drv(0, 1, 0, 1, 1, b, a); endtask
  task automatic wr(int b, int a); drv(0, 1, 0, 0, 1, b, a); endtask
  task automatic pre(int b, bit all); drv(0, 0, 1, 0, 1, b, all ? 1024 : 0); endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #400000;
    checks++; errors++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; cke = 1;
    @(negedge clk);
    tag = "R11";
    chk("reset open", bank_open, 0); chk("reset rows", open_rows == 0, 1);
    chk("reset cmd", cmd, 0); chk("reset err", cmd_err, 0); chk("reset pd", pdown, 0);
    live = 1;
    tag = "R1";  drv(0, 0, 0, 0, 1, 0, 5); nop(3); drv(0, 1, 1, 0, 1, 0, 0); nop(1);
    tag = "R8";  drv(0, 0, 0, 1, 1, 0, 0); nop(1);
    tag = "R2";  drv(1, 0, 1, 1, 1, 2, 9); nop(1);
    tag = "R3";  act(0, 16'h1234); act(3, 16'h0abc); act(7, 16'h3fff); nop(1);
    tag = "R4";  act(3, 16'h0111); nop(1);
    tag = "R5";  rd(1, 0); wr(2, 0); nop(5);
    tag = "R6";  rd(3, 1024); nop(5); wr(7, 8); nop(5); wr(7, 1024); nop(5);
    act(7, 77); rd(7, 0); nop(5);
    tag = "R8";  drv(0, 0, 0, 1, 1, 0, 0); nop(1);
    tag = "R7";  pre(0, 0); pre(4, 0); act(2, 5); act(6, 6); pre(1, 1); nop(1);
    tag = "R10";
    act(5, 55);
    for (int off = 0; off < 7; off++) begin
      rd(5, 0); nop(off); drv(0, 1, 1, 1, 0, 0, 0); nop(6);
    end
    drv(0, 0, 0, 0, 1, 0, 0); nop(1); drv(0, 1, 1, 1, 0, 0, 0); nop(4);
    drv(0, 0, 1, 1, 0, 1, 9); drv(0, 1, 1, 1, 0, 0, 0); nop(2);
    tag = "R9";  pre(0, 1); nop(1); drv(1, 1, 1, 1, 0, 0, 0); drv(1, 1, 1, 1, 0, 0, 0);
    tag = "R2";  drv(0, 0, 1, 1, 0, 1, 42); drv(0, 0, 0, 1, 0, 0, 0);
    tag = "R9";  nop(2); drv(0, 1, 1, 1, 0, 0, 0); nop(2);
    finish_run();
  end
endmodule